// File: doc/BRIEF.md
# Modulus Timer Counter with Overflow Flag

This block is a free-running timer counter with a programmable terminal count. In plain up mode it counts from zero to a limit, then wraps back to zero. In up/down mode it climbs to the limit, turns around and descends to zero, then climbs again, which gives the triangular carrier used for center-aligned PWM. In each mode the wrap point raises a sticky overflow flag. The flag is set at a different point in the period depending on the mode.

Software clears the flag with a two-step handshake. It first reads the flag while the flag is set, then writes zero to it. If a new overflow arrives between the two steps, the handshake is voided, so no event is lost. An enable input gates the flag onto a level-sensitive interrupt request. Clock prescaling and PWM pin generation live outside this block.

Top module: `tmr_modulus_top`

## Requirements
- R1: With a modulus of zero in up mode (`updown_i`=0), the count runs through the full range 0 to 2^CNT_W-1. The step from the all-ones value back to 0 sets the overflow flag in the same clock edge.
- R2: With a nonzero modulus M in up mode, the count goes from M to 0 on the next enabled edge, and that edge sets the flag. Counts below M do not set it.
- R3: In up/down mode (`updown_i`=1), an enabled edge at count M while counting up (`dir_down_o`=0) moves the count to M-1 and sets `dir_down_o`=1. Only this step sets the flag.
- R4: In up/down mode, an enabled edge at count 0 while counting down moves the count to 1 and sets `dir_down_o`=0. Count 0 is the center of the period, and this reversal leaves the flag unchanged.
- R5: A cycle with `flag_rd_i`=1 while the flag is 1 arms the clear. A later cycle with `flag_wr_i`=1 and `flag_wdata_i`=0 then clears the flag.
- R6: An overflow between the arming read and the zero write disarms the clear, and the flag stays 1 after that write.
- R7: `irq_o` is 1 exactly while the flag is 1 and `ovf_ie_i` is 1.
- R8: A zero write with no earlier arming read leaves the flag unchanged. A write of 1 never changes the flag.
- R9: While `cnt_en_i`=0, the count and the direction hold their values.
- R10: After reset the count is 0, the direction is up, and the flag and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| updown_i | input | 1 | 0 selects up mode, 1 selects up/down mode |
| modulus_i | input | CNT_W | Terminal count; 0 selects the full range |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| flag_rd_i | input | 1 | Flag read strobe |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write value |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench builds the block with CNT_W=8. This places the full-range wrap with a modulus of zero 256 edges from reset, so that case is exercised directly and not inferred from small moduli. Small moduli of 3 and 5 keep both reversals of up/down mode and an overflow that lands inside an open clear handshake within a few cycles. The width does not change the comparison logic, so the 16-bit default behaves in the same way.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    MODE_UP   = 1'b0,
    MODE_UPDN = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             updown_i,
  input  logic [CNT_W-1:0] modulus_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_down_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  cnt_mode_e        mode;
  logic [CNT_W-1:0] lim, cnt_q, cnt_d;
  logic             dir_q, dir_d, wrap;

  assign mode = cnt_mode_e'(updown_i);
  assign lim  = (modulus_i == '0) ? CNT_MAX : modulus_i;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (en_i) begin
      if (mode == MODE_UP) begin
        dir_d = 1'b0;
        if (cnt_q >= lim) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else if (!dir_q) begin
        if (cnt_q >= lim) begin
          // end of PWM period: turn around at the limit
          cnt_d = lim - CNT_ONE;
          dir_d = 1'b1;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = CNT_ONE;
          dir_d = 1'b0;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;
  assign wrap_o     = wrap;

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(dir_q)));

  // R2
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !updown_i && cnt_q == lim) |=> (cnt_q == '0));

  // R3
  top_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && updown_i && !dir_q && cnt_q == lim) |=> (dir_q && cnt_q == $past(lim) - CNT_ONE));

  // R4
  center_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && updown_i && dir_q && cnt_q == '0) |=> (!dir_q && cnt_q == CNT_ONE));
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_data_i,
  output logic flag_o
);
  logic flag_q, armed_q;
  logic clr_ok;

  assign clr_ok = wr_i && !wr_data_i && armed_q && !set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_i)       flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      // a new event or any write closes the handshake
      if (set_i || wr_i)       armed_q <= 1'b0;
      else if (rd_i && flag_q) armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R1
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

  // R5
  clr_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(armed_q) && $past(wr_i) && !$past(wr_data_i)));

  // R8
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_i && !wr_data_i)) |=> flag_q);

  // R6
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !armed_q);
endmodule

// File: rtl/tmr_modulus_top.sv
module tmr_modulus_top #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             updown_i,
  input  logic [CNT_W-1:0] modulus_i,
  input  logic             ovf_ie_i,
  input  logic             flag_rd_i,
  input  logic             flag_wr_i,
  input  logic             flag_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  logic wrap;

  tmr_count_core #(.CNT_W(CNT_W)) core_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cnt_en_i),
    .updown_i   (updown_i),
    .modulus_i  (modulus_i),
    .cnt_o      (count_o),
    .dir_down_o (dir_down_o),
    .wrap_o     (wrap)
  );

  tmr_ovf_flag flag_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (wrap),
    .rd_i      (flag_rd_i),
    .wr_i      (flag_wr_i),
    .wr_data_i (flag_wdata_i),
    .flag_o    (ovf_flag_o)
  );

  assign irq_o = ovf_flag_o & ovf_ie_i;

  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_flag_o && ovf_ie_i));
endmodule

// File: tb/tmr_modulus_top_tb_top.sv
module tmr_modulus_top_tb_top;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cnt_en_i = 1'b0, updown_i = 1'b0, ovf_ie_i = 1'b0;
  logic         flag_rd_i = 1'b0, flag_wr_i = 1'b0, flag_wdata_i = 1'b0;
  logic [W-1:0] modulus_i = '0;
  logic [W-1:0] count_o;
  logic         dir_down_o, ovf_flag_o, irq_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tmr_modulus_top #(.CNT_W(W)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cnt_en_i = 1'b0; flag_rd_i = 1'b0; flag_wr_i = 1'b0;
    ticks(2);
    rst_ni = 1'b1;
    ticks(1);
  endtask

  task automatic rd_pulse();
    flag_rd_i = 1'b1; ticks(1); flag_rd_i = 1'b0;
  endtask

  task automatic wr_pulse(input logic v);
    flag_wr_i = 1'b1; flag_wdata_i = v; ticks(1); flag_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 count", int'(count_o), 0);
    check("R10 dir", int'(dir_down_o), 0);
    check("R10 flag", int'(ovf_flag_o), 0);
    check("R10 irq", int'(irq_o), 0);
  endtask

  task automatic t_full_range();
    do_reset(); updown_i = 1'b0; modulus_i = '0; cnt_en_i = 1'b1;
    ticks(255);
    check("R1 count at max", int'(count_o), 255);
    check("R1 no flag before wrap", int'(ovf_flag_o), 0);
    ticks(1);
    check("R1 wrap count", int'(count_o), 0);
    check("R1 flag on wrap", int'(ovf_flag_o), 1);
    cnt_en_i = 1'b0;
    ticks(3);
    check("R9 hold count", int'(count_o), 0);
  endtask

  task automatic t_modulus_up();
    do_reset(); updown_i = 1'b0; modulus_i = 8'd9; cnt_en_i = 1'b1;
    ticks(9);
    check("R2 count at M", int'(count_o), 9);
    check("R2 no early flag", int'(ovf_flag_o), 0);
    ticks(1);
    check("R2 wrap count", int'(count_o), 0);
    check("R2 flag", int'(ovf_flag_o), 1);
  endtask

  task automatic t_updown();
    do_reset(); updown_i = 1'b1; modulus_i = 8'd5; cnt_en_i = 1'b1;
    ticks(5);
    check("R3 count at M", int'(count_o), 5);
    check("R3 dir up", int'(dir_down_o), 0);
    check("R3 no flag at M", int'(ovf_flag_o), 0);
    ticks(1);
    check("R3 count M-1", int'(count_o), 4);
    check("R3 dir down", int'(dir_down_o), 1);
    check("R3 flag", int'(ovf_flag_o), 1);
    cnt_en_i = 1'b0;
    ticks(2);
    check("R9 hold dir", int'(dir_down_o), 1);
    check("R9 hold count", int'(count_o), 4);
    rd_pulse(); wr_pulse(1'b0);
    check("R5 cleared", int'(ovf_flag_o), 0);
    cnt_en_i = 1'b1;
    ticks(4);
    check("R4 center", int'(count_o), 0);
    check("R4 still down", int'(dir_down_o), 1);
    ticks(1);
    check("R4 count 1", int'(count_o), 1);
    check("R4 dir up", int'(dir_down_o), 0);
    check("R4 no flag", int'(ovf_flag_o), 0);
  endtask

  task automatic t_clear();
    do_reset(); updown_i = 1'b0; modulus_i = 8'd3; cnt_en_i = 1'b1;
    ticks(4);
    cnt_en_i = 1'b0;
    check("R2 flag M=3", int'(ovf_flag_o), 1);
    wr_pulse(1'b0);
    check("R8 zero write unarmed", int'(ovf_flag_o), 1);
    rd_pulse(); wr_pulse(1'b1);
    check("R8 one write", int'(ovf_flag_o), 1);
    wr_pulse(1'b0);
    check("R8 write after closed", int'(ovf_flag_o), 1);
    rd_pulse();
    cnt_en_i = 1'b1; ticks(4); cnt_en_i = 1'b0;
    check("R6 new wrap count", int'(count_o), 0);
    wr_pulse(1'b0);
    check("R6 flag kept", int'(ovf_flag_o), 1);
    rd_pulse(); wr_pulse(1'b0);
    check("R5 flag cleared", int'(ovf_flag_o), 0);
    rd_pulse(); wr_pulse(1'b0);
    check("R5 stays clear", int'(ovf_flag_o), 0);
  endtask

  task automatic t_irq();
    do_reset(); updown_i = 1'b0; modulus_i = 8'd2; ovf_ie_i = 1'b1; cnt_en_i = 1'b1;
    ticks(2);
    check("R7 irq no flag", int'(irq_o), 0);
    ticks(1); cnt_en_i = 1'b0;
    check("R7 irq on", int'(irq_o), 1);
    ticks(3);
    check("R7 irq level", int'(irq_o), 1);
    ovf_ie_i = 1'b0; ticks(1);
    check("R7 irq masked", int'(irq_o), 0);
    ovf_ie_i = 1'b1; rd_pulse(); wr_pulse(1'b0);
    check("R7 irq after clear", int'(irq_o), 0);
  endtask

  initial begin
    t_reset();
    t_full_range();
    t_modulus_up();
    t_updown();
    t_clear();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule